// File: doc/BRIEF.md
# Synthesiser Divider, Phase Comparator and Lock Control

This block is the digital heart of a frequency-synthesiser phase-locked loop. It divides the reference oscillator by a ratio picked from a five-entry mode table. It also divides the prescaled RF signal by a loaded 15-bit divisor. It then compares the two divided signals in phase and frequency and issues pump-up or pump-down requests to an external charge pump. A lock detector watches the width of those requests. While the loop is out of lock the pump current level is high, and once lock is reached it drops to low. An open-drain style lock flag reports the lock state.

The block runs on one fast sampling clock. The reference oscillator and the prescaler output arrive as single-cycle `ref_tick` and `rf_tick` strobes. The divisor word, the word-length flag and the four port bits come from the holding registers of a serial loader. When `test_en` is high, the port bits act as a test code instead. The code can force the pump direction and level, force the lock flag, or send the internal divided signals out on two port pins. All outputs are registered, one clock after the logic that feeds them.

Top module: `synth_pll_core`

## Requirements
- R1: The reference ratio in `ref_tick` strobes is 640 for `mode` 0, 2048 for 1, 1024 for 2, 1280 for 3 and 512 for 4. Codes 5, 6 and 7 use 512. The divided reference is high for the first half of each period.
- R2: The feedback divider counts N `rf_tick` strobes per period. With `long_word`=1, N is `div_word`. With `long_word`=0, bit 14 is treated as 0. Any N below 2 is raised to 2.
- R3: A changed divisor or mode is sampled only at the divider's terminal count, so the period in progress finishes with its old length.
- R4: A reference edge that leads raises `pump_up` until the feedback edge arrives. A feedback edge that leads raises `pump_dn` until the reference edge arrives. The two are never high together.
- R5: Reference and feedback edges that fall in the same clock cycle produce no pump request.
- R6: `lock_flag` rises once 8 consecutive reference periods have passed with no request pulse lasting `LOCK_THR` (4) clocks or more. Outside test mode, `pump_lvl` is 1 (high current) while unlocked and 0 (low current) while locked.
- R7: A request pulse of `LOCK_THR` clocks or more clears the lock at the end of that reference period. Pulses shorter than that leave the lock in place.
- R8: With `test_en`=1 and the code {P1,P2,P3} = {port_bits[1],port_bits[2],port_bits[3]} of 000, 001, 100 or 101, the pump is forced. P3=0 gives down and P3=1 gives up. The level is 2 (test current) when P1=0 and 0 when P1=1.
- R9: With `test_en`=1, P2=1 and P3=0, `port_sink[2]` carries the divided reference and `port_sink[3]` carries the feedback divided by two, toggling at each terminal count. `lock_flag` is forced to 0.
- R10: With `test_en`=1, P2=1 and P3=1, `lock_flag` is forced to 1.
- R11: Outside test mode, `port_sink` follows `port_bits`, one register stage later.
- R12: During reset, `pump_up`, `pump_dn`, `lock_flag` and `port_sink` are 0, and `pump_lvl` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ref_tick | input | 1 | One strobe per reference oscillator cycle |
| rf_tick | input | 1 | One strobe per prescaler output cycle |
| mode | input | 3 | Reference ratio select |
| div_word | input | 15 | Feedback divisor from the holding register |
| long_word | input | 1 | 1 = full 15-bit divisor, 0 = bit 14 treated as 0 |
| port_bits | input | 4 | Port bits, index i is port Pi; also the test code |
| test_en | input | 1 | Test mode enable |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| pump_lvl | output | 2 | Pump current: 0 low, 1 high, 2 test |
| lock_flag | output | 1 | 1 = released (locked), 0 = pulled low |
| port_sink | output | 4 | Port pins, 1 = sinking |

## Verification
The bench builds the block with its default parameters: a 15-bit divisor, a lock count of 8 and a width threshold of 4. With these values, every mode in the table can be measured through the routed test pins. The full 15-bit divisor path with bit 14 set can be exercised within the cycle budget. Holding `rf_tick` low for 2 or 6 clocks places a phase lag just under and just over the width threshold, so both the lock-keeping side and the lock-losing side are reached.

// File: rtl/synth_pkg.sv
package synth_pkg;

    localparam int MODE_W    = 3;
    localparam int REF_CNT_W = 12;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_TEST = 2'd2
    } pump_lvl_e;

    function automatic logic [REF_CNT_W-1:0] ref_ratio(input logic [MODE_W-1:0] sel);
        logic [REF_CNT_W-1:0] r;
        case (sel)
            3'd0:    r = REF_CNT_W'(640);
            3'd1:    r = REF_CNT_W'(2048);
            3'd2:    r = REF_CNT_W'(1024);
            3'd3:    r = REF_CNT_W'(1280);
            default: r = REF_CNT_W'(512);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/synth_ref_div.sv
module synth_ref_div
    import synth_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [MODE_W-1:0] mode,
    output logic              strobe,
    output logic              lvl
);
    typedef struct packed {
        logic [REF_CNT_W-1:0] cnt;
        logic [REF_CNT_W-1:0] half;
        logic                 strobe;
    } ref_st_t;

    ref_st_t st_d, st_q;
    logic [REF_CNT_W-1:0] ratio;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        ratio       = ref_ratio(mode);
        if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt    = ratio - REF_CNT_W'(1);
                st_d.half   = ratio >> 1;
                st_d.strobe = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - REF_CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, half: '1, strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q.strobe;
    assign lvl    = (st_q.cnt >= st_q.half);

endmodule

// File: rtl/synth_prog_div.sv
module synth_prog_div #(
    parameter int DIV_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_word,
    input  logic             long_word,
    output logic             strobe,
    output logic             half_out
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             strobe;
        logic             half;
    } fb_st_t;

    fb_st_t st_d, st_q;
    logic [DIV_W-1:0] n_raw, n_eff;

    always_comb begin
        n_raw = long_word ? div_word : {1'b0, div_word[DIV_W-2:0]};
        n_eff = (n_raw < MIN_DIV) ? MIN_DIV : n_raw;

        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt    = n_eff - DIV_W'(1);
                st_d.strobe = 1'b1;
                st_d.half   = ~st_q.half;
            end else begin
                st_d.cnt = st_q.cnt - DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, strobe: 1'b0, half: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe   = st_q.strobe;
    assign half_out = st_q.half;

endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_s,
    input  logic fb_s,
    output logic up,
    output logic dn
);
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_st_t;

    pfd_st_t st_d, st_q;

    always_comb begin
        st_d.up = st_q.up | ref_s;
        st_d.dn = st_q.dn | fb_s;
        if (st_d.up && st_d.dn) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign up = st_q.up;
    assign dn = st_q.dn;

endmodule

// File: rtl/synth_lock_det.sv
module synth_lock_det #(
    parameter int LOCK_CYCLES = 8,
    parameter int LOCK_THR    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_s,
    input  logic active,
    output logic locked
);
    localparam int GW = $clog2(LOCK_CYCLES + 1);
    localparam int WW = $clog2(LOCK_THR + 1);

    typedef struct packed {
        logic [WW-1:0] wcnt;
        logic          bad;
        logic [GW-1:0] good;
        logic          locked;
    } lk_st_t;

    lk_st_t st_d, st_q;
    logic   wide;
    logic   bad_now;

    always_comb begin
        st_d = st_q;
        wide = active && ((int'(st_q.wcnt) + 1) >= LOCK_THR);
        if (active) begin
            if (int'(st_q.wcnt) < LOCK_THR) begin
                st_d.wcnt = st_q.wcnt + WW'(1);
            end
        end else begin
            st_d.wcnt = '0;
        end

        bad_now = st_q.bad | wide;
        if (ref_s) begin
            st_d.bad = 1'b0;
            if (bad_now) begin
                st_d.good   = '0;
                st_d.locked = 1'b0;
            end else if (int'(st_q.good) < LOCK_CYCLES) begin
                st_d.good = st_q.good + GW'(1);
                if ((int'(st_q.good) + 1) == LOCK_CYCLES) begin
                    st_d.locked = 1'b1;
                end
            end
        end else begin
            st_d.bad = bad_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;

endmodule

// File: rtl/synth_pll_core.sv
module synth_pll_core
    import synth_pkg::*;
#(
    parameter int DIV_W       = 15,
    parameter int LOCK_CYCLES = 8,
    parameter int LOCK_THR    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              rf_tick,
    input  logic [MODE_W-1:0] mode,
    input  logic [DIV_W-1:0]  div_word,
    input  logic              long_word,
    input  logic [3:0]        port_bits,
    input  logic              test_en,
    output logic              pump_up,
    output logic              pump_dn,
    output logic [1:0]        pump_lvl,
    output logic              lock_flag,
    output logic [3:0]        port_sink
);
    logic ref_s_w, fcomp_lvl_w;
    logic fb_s_w, fpd_half_w;
    logic pfd_up_w, pfd_dn_w;
    logic locked_w;

    synth_ref_div i_ref_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ref_tick),
        .mode   (mode),
        .strobe (ref_s_w),
        .lvl    (fcomp_lvl_w)
    );

    synth_prog_div #(.DIV_W(DIV_W)) i_prog_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (rf_tick),
        .div_word  (div_word),
        .long_word (long_word),
        .strobe    (fb_s_w),
        .half_out  (fpd_half_w)
    );

    synth_pfd i_pfd (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_s (ref_s_w),
        .fb_s  (fb_s_w),
        .up    (pfd_up_w),
        .dn    (pfd_dn_w)
    );

    synth_lock_det #(
        .LOCK_CYCLES (LOCK_CYCLES),
        .LOCK_THR    (LOCK_THR)
    ) i_lock_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_s  (ref_s_w),
        .active (pfd_up_w | pfd_dn_w),
        .locked (locked_w)
    );

    typedef struct packed {
        logic       up;
        logic       dn;
        pump_lvl_e  lvl;
        logic       lock;
        logic [3:0] ports;
    } out_st_t;

    out_st_t out_d, out_q;

    always_comb begin
        out_d.up    = pfd_up_w;
        out_d.dn    = pfd_dn_w;
        out_d.lvl   = locked_w ? LVL_LOW : LVL_HIGH;
        out_d.lock  = locked_w;
        out_d.ports = port_bits;
        if (test_en) begin
            if (!port_bits[2]) begin
                out_d.up  = port_bits[3];
                out_d.dn  = ~port_bits[3];
                out_d.lvl = port_bits[1] ? LVL_LOW : LVL_TEST;
            end else if (!port_bits[3]) begin
                out_d.ports[2] = fcomp_lvl_w;
                out_d.ports[3] = fpd_half_w;
                out_d.lock     = 1'b0;
            end else begin
                out_d.lock = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{up: 1'b0, dn: 1'b0, lvl: LVL_HIGH, lock: 1'b0, ports: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign pump_up   = out_q.up;
    assign pump_dn   = out_q.dn;
    assign pump_lvl  = out_q.lvl;
    assign lock_flag = out_q.lock;
    assign port_sink = out_q.ports;

endmodule

// File: rtl/synth_pll_core_chk.sv
module synth_pll_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       test_en,
    input logic [3:0] port_bits,
    input logic       pump_up,
    input logic       pump_dn,
    input logic [1:0] pump_lvl,
    input logic       lock_flag,
    input logic [3:0] port_sink,
    input logic       locked,
    input logic       ref_strobe
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    p_pump_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    p_lvl_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(test_en)) |-> (pump_lvl == ($past(locked) ? 2'd0 : 2'd1)));

    p_lock_at_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(locked)) |-> $past(ref_strobe));

    p_test_pump_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(test_en) && !$past(port_bits[2])) |->
        ((pump_up == $past(port_bits[3])) && (pump_dn == !$past(port_bits[3])) &&
         (pump_lvl == ($past(port_bits[1]) ? 2'd0 : 2'd2))));

    p_force_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(test_en) && ($past(port_bits[3:2]) == 2'b01)) |-> !lock_flag);

    p_force_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(test_en) && ($past(port_bits[3:2]) == 2'b11)) |-> lock_flag);

    p_ports_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(test_en)) |-> (port_sink == $past(port_bits)));

endmodule

bind synth_pll_core synth_pll_core_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_en    (test_en),
    .port_bits  (port_bits),
    .pump_up    (pump_up),
    .pump_dn    (pump_dn),
    .pump_lvl   (pump_lvl),
    .lock_flag  (lock_flag),
    .port_sink  (port_sink),
    .locked     (locked_w),
    .ref_strobe (ref_s_w)
);

// File: tb/test_synth_pll_core.sv
module test_synth_pll_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_tick, rf_tick;
    logic [2:0]  mode;
    logic [14:0] div_word;
    logic        long_word;
    logic [3:0]  port_bits;
    logic        test_en;
    logic        pump_up, pump_dn;
    logic [1:0]  pump_lvl;
    logic        lock_flag;
    logic [3:0]  port_sink;

    int n_checks = 0;
    int n_fail   = 0;
    int up_seen  = 0;
    int dn_seen  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_pll_core i_synth_pll_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .rf_tick   (rf_tick),
        .mode      (mode),
        .div_word  (div_word),
        .long_word (long_word),
        .port_bits (port_bits),
        .test_en   (test_en),
        .pump_up   (pump_up),
        .pump_dn   (pump_dn),
        .pump_lvl  (pump_lvl),
        .lock_flag (lock_flag),
        .port_sink (port_sink)
    );

    always @(negedge clk) begin
        if (pump_up) up_seen <= up_seen + 1;
        if (pump_dn) dn_seen <= dn_seen + 1;
    end

    function automatic int exp_ratio(input int m);
        case (m)
            0: return 640;
            1: return 2048;
            2: return 1024;
            3: return 1280;
            default: return 512;
        endcase
    endfunction

    function automatic int exp_div(input int w, input bit lw);
        int n;
        n = lw ? (w & 32'h7FFF) : (w & 32'h3FFF);
        return (n < 2) ? 2 : n;
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_port(input int idx, input logic val);
        while (port_sink[idx] !== val) @(negedge clk);
    endtask

    task automatic count_until(input int idx, input logic val, output int c);
        c = 0;
        do begin
            @(negedge clk);
            c++;
        end while (port_sink[idx] !== val);
    endtask

    task automatic measure_period(input int idx, output int per);
        int c1, c2;
        wait_port(idx, 1'b0);
        wait_port(idx, 1'b1);
        count_until(idx, 1'b0, c1);
        count_until(idx, 1'b1, c2);
        per = c1 + c2;
    endtask

    task automatic measure_high(output int hi);
        wait_port(3, 1'b0);
        wait_port(3, 1'b1);
        count_until(3, 1'b0, hi);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int u0, d0, v, seed;
        seed = $urandom(32'd5150);
        rst_n = 1'b0; ref_tick = 1'b1; rf_tick = 1'b1; mode = 3'd4;
        div_word = 15'd512; long_word = 1'b0; port_bits = 4'b0000; test_en = 1'b0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check_eq("R12 pump_up", int'(pump_up), 0);
        check_eq("R12 pump_dn", int'(pump_dn), 0);
        check_eq("R12 pump_lvl", int'(pump_lvl), 1);
        check_eq("R12 lock_flag", int'(lock_flag), 0);
        check_eq("R12 port_sink", int'(port_sink), 0);
        u0 = up_seen; d0 = dn_seen;
        rst_n = 1'b1;

        // R6 lock acquisition with matched dividers; R5 no requests
        repeat (6*512) @(negedge clk);
        check_eq("R6 early lock_flag", int'(lock_flag), 0);
        check_eq("R6 early pump_lvl", int'(pump_lvl), 1);
        repeat (4*512) @(negedge clk);
        check_eq("R6 lock_flag", int'(lock_flag), 1);
        check_eq("R6 pump_lvl", int'(pump_lvl), 0);
        check_eq("R5 up count", up_seen - u0, 0);
        check_eq("R5 dn count", dn_seen - d0, 0);

        // R7 small lag keeps lock; R4 feedback lags gives up only
        u0 = up_seen; d0 = dn_seen;
        rf_tick = 1'b0; repeat (2) @(negedge clk); rf_tick = 1'b1;
        repeat (12*512) @(negedge clk);
        check_eq("R7 small lag lock_flag", int'(lock_flag), 1);
        check_eq("R4 up seen", int'(up_seen - u0 > 0), 1);
        check_eq("R4 no dn", dn_seen - d0, 0);
        rf_tick = 1'b0; repeat (6) @(negedge clk); rf_tick = 1'b1;
        repeat (3*512) @(negedge clk);
        check_eq("R7 wide lag lock_flag", int'(lock_flag), 0);
        check_eq("R6 lost pump_lvl", int'(pump_lvl), 1);

        // R4 feedback faster gives down only
        div_word = 15'd400;
        do_reset();
        u0 = up_seen; d0 = dn_seen;
        repeat (10*512) @(negedge clk);
        check_eq("R4 dn seen", int'(dn_seen - d0 > 0), 1);
        check_eq("R4 no up", up_seen - u0, 0);
        check_eq("R4 unlocked", int'(lock_flag), 0);

        // R8 forced pump codes
        test_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            logic p1, p3;
            p1 = k[1]; p3 = k[0];
            port_bits = {p3, 1'b0, p1, 1'b0};
            repeat (2) @(negedge clk);
            check_eq("R8 pump_up", int'(pump_up), int'(p3));
            check_eq("R8 pump_dn", int'(pump_dn), int'(!p3));
            check_eq("R8 pump_lvl", int'(pump_lvl), p1 ? 0 : 2);
        end

        // R10 force in lock (P1 both values)
        port_bits = 4'b1100; repeat (2) @(negedge clk);
        check_eq("R10 lock_flag P1=0", int'(lock_flag), 1);
        port_bits = 4'b1110; repeat (2) @(negedge clk);
        check_eq("R10 lock_flag P1=1", int'(lock_flag), 1);

        // R9 routing and forced out of lock; R1 ratios
        port_bits = 4'b0111; repeat (2) @(negedge clk);
        check_eq("R9 lock_flag", int'(lock_flag), 0);
        check_eq("R9 port_sink[1:0]", int'(port_sink[1:0]), 3);
        for (int m = 0; m < 8; m++) begin
            mode = 3'(m);
            measure_period(2, v);
            check_eq($sformatf("R1 ratio mode %0d", m), v, exp_ratio(m));
        end
        mode = 3'd4;

        // R2 feedback divisor via routed P3
        div_word = 15'h4000 | 15'd300; long_word = 1'b0;
        measure_high(v); measure_high(v);
        check_eq("R2 short word masks bit 14", v, 300);
        div_word = 15'd1;
        measure_high(v); measure_high(v);
        check_eq("R2 divisor 1 raised to 2", v, 2);
        div_word = 15'd0;
        measure_high(v); measure_high(v);
        check_eq("R2 divisor 0 raised to 2", v, 2);
        div_word = 15'h4000 | 15'd7; long_word = 1'b1;
        measure_high(v); measure_high(v);
        check_eq("R2 long word", v, exp_div(32'h4007, 1'b1));
        long_word = 1'b0;
        for (int i = 0; i < 6; i++) begin
            int w;
            w = int'($urandom_range(2, 900)) | (int'($urandom_range(0, 1)) << 14);
            div_word = 15'(w);
            measure_high(v); measure_high(v);
            check_eq("R2 random divisor", v, exp_div(w, 1'b0));
        end

        // R3 change mid period finishes old length
        div_word = 15'd200;
        measure_high(v);
        wait_port(3, 1'b0);
        wait_port(3, 1'b1);
        repeat (5) @(negedge clk);
        div_word = 15'd350;
        begin
            int c1, c2;
            count_until(3, 1'b0, c1);
            count_until(3, 1'b1, c2);
            check_eq("R3 old period kept", c1 + 5, 200);
            check_eq("R3 new period used", c2, 350);
        end

        // R11 normal port pass-through
        test_en = 1'b0;
        for (int i = 0; i < 16; i++) begin
            logic [3:0] pb;
            pb = 4'($urandom_range(0, 15));
            port_bits = pb;
            repeat (2) @(negedge clk);
            check_eq("R11 port_sink", int'(port_sink), int'(pb));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule